// File: doc/BRIEF.md
# Quadrature Position Counter with Capture Control

This block turns the two phase-shifted channels of an incremental encoder into a 16-bit up/down position count. It samples the channels at one, two or four counts per encoder cycle, picks the direction from which channel leads, and stops counting while the gate input is high. A host writes a control byte and a preset value on the block's own clock. It reads back a status byte, the live count and a capture register. The capture register takes the count on the first rising edge of the index input or of an external latch input, and only while the matching enable bit is set.

The encoder channels, index, latch and gate inputs each pass through a two-flop synchroniser before any edge is detected. Each of four small state machines owns one concern.

- **Decoder.** It holds the last phase as a state. The states are `PH_00`, `PH_10`, `PH_11` and `PH_01`, named after the {A,B} level pair. The forward transitions run 00→10→11→01→00. The reverse transitions run the opposite way. A jump in which both bits change is illegal and gives no count.
- **Wrap tracker.** Its states are `WRAP_CLEAR`, `WRAP_OVER` and `WRAP_UNDER`. CLEAR or UNDER moves to OVER on an up step from 65535. CLEAR or OVER moves to UNDER on a down step from 0. OVER returns to CLEAR on an up step from 21845. UNDER returns to CLEAR on a down step from 43690.
- **Capture machines.** There is one per source. Their states are `CAP_OFF`, `CAP_ARMED` and `CAP_HELD`. OFF moves to ARMED when the enable is seen. ARMED moves to HELD on a rising edge, and the count is taken at that moment. ARMED or HELD falls back to OFF when the enable drops.

Top module: `quad_counter`

## Requirements
- R1: After reset the count, the capture value and the status byte are all zero.
- R2: With `mult_sel` 0 or 3 (four-times mode), every legal {A,B} change counts. A change along 00→10→11→01→00 adds one, and a change in the opposite order subtracts one.
- R3: With `mult_sel` 1 (two-times mode), only legal changes of A count, with the direction of R2. Changes of B alone leave the count unchanged.
- R4: With `mult_sel` 2 (one-times mode), only the change between {A,B}=00 and 10 counts: 00→10 adds one and 10→00 subtracts one. All other changes leave the count unchanged.
- R5: While `gate_in` is high, no change counts. A change in which A and B flip together never counts.
- R6: A 0→1 change of control bit 2 loads `preset_value` into the count and sets status bit 2. Status bit 2 stays set until control bit 2 returns to 0.
- R7: Status bit 4 (overflow) sets when the count wraps from 65535 to 0. It clears on an up step from 21845 to 21846 or when an underflow occurs. Loading a preset does not change it.
- R8: Status bit 3 (underflow) sets when the count wraps from 0 to 65535. It clears on a down step from 43690 to 43689 or when an overflow occurs.
- R9: While control bit 1 is set, only the first rising edge of `latch_in` copies the count into `latch_value` and sets status bit 1. Later edges change nothing. Clearing control bit 1 clears status bit 1, keeps `latch_value`, and re-arms capture. With the bit clear, edges are ignored.
- R10: Control bit 0 and `enc_index` behave as in R9, with status bit 0 as the valid flag.
- R11: While control bit 5 (fast mode) is set, bits 0 to 2 are treated as zero: no preset, no capture, all acknowledge bits clear. Counting continues. Control bits 3, 4, 6 and 7 are spare and held at zero by the host. Status bits 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| enc_a | input | 1 | Encoder channel A (asynchronous) |
| enc_b | input | 1 | Encoder channel B (asynchronous) |
| enc_index | input | 1 | Encoder index pulse (asynchronous) |
| latch_in | input | 1 | External capture request (asynchronous) |
| gate_in | input | 1 | High stops counting (asynchronous) |
| mult_sel | input | 2 | Sampling multiple: 0/3 four-times, 1 two-times, 2 one-times |
| ctrl_byte | input | 8 | Control: bit0 index capture enable, bit1 external capture enable, bit2 preset request, bit5 fast mode |
| preset_value | input | CNT_W | Value loaded on a preset request |
| status_byte | output | 8 | bit0 index valid, bit1 external valid, bit2 preset ack, bit3 underflow, bit4 overflow |
| count_value | output | CNT_W | Live count |
| latch_value | output | CNT_W | Last captured count |

## Verification
The bench builds the block with its default values, `CNT_W` = 16 and `SYNC_STAGES` = 2. The 16-bit width puts the exact wrap points (65535/0) and the hysteresis crossings (21845/21846 and 43690/43689) within reach, because the bench presets the count to one step before each of them. The two-stage synchroniser keeps the input-to-count delay at three clocks, so a fixed settle time after each stimulus covers every path. A vector table walks each sampling multiple in both directions, together with the gated and double-jump cases. Directed sequences then cover preset, flag set and clear, first-edge capture, re-arming and fast mode.

// File: rtl/qc_pkg.sv
package qc_pkg;

    // Control byte bit positions (host-visible encoding)
    localparam int CB_IDX_EN = 0;
    localparam int CB_EXT_EN = 1;
    localparam int CB_PRESET = 2;
    localparam int CB_FAST   = 5;
    localparam logic [7:0] CB_SPARE_MASK = 8'hD8;

    typedef enum logic [1:0] {
        MULT_X4  = 2'd0,
        MULT_X2  = 2'd1,
        MULT_X1  = 2'd2,
        MULT_X4B = 2'd3
    } mult_t;

    // {A,B} level pair as decoder state
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_t;

    typedef enum logic [1:0] {
        CAP_OFF   = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_HELD  = 2'd2
    } cap_state_t;

    typedef enum logic [1:0] {
        WRAP_CLEAR = 2'd0,
        WRAP_OVER  = 2'd1,
        WRAP_UNDER = 2'd2
    } wrap_state_t;

    // Successor of a phase in the forward (A leads) direction
    function automatic phase_t fwd_next(input phase_t p);
        phase_t n;
        unique case (p)
            PH_00:   n = PH_10;
            PH_10:   n = PH_11;
            PH_11:   n = PH_01;
            PH_01:   n = PH_00;
            default: n = PH_00;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/qc_decoder.sv
module qc_decoder
    import qc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_in,
    input  logic       gate,
    input  logic [1:0] mult,
    output logic       step_up,
    output logic       step_dn
);
    phase_t prev_q;
    phase_t cur;
    logic   is_fwd;
    logic   is_rev;
    logic   keep;
    logic   a_moved;

    assign cur = phase_t'(ab_in);

    // State register: last seen phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= PH_00;
        else        prev_q <= cur;
    end

    // Outputs: qualified step pulses
    always_comb begin
        is_fwd  = (cur == fwd_next(prev_q));
        is_rev  = (prev_q == fwd_next(cur));
        a_moved = ab_in[1] ^ prev_q[1];
        unique case (mult_t'(mult))
            MULT_X2:  keep = a_moved;
            MULT_X1:  keep = ((prev_q == PH_00) && (cur == PH_10)) ||
                             ((prev_q == PH_10) && (cur == PH_00));
            MULT_X4,
            MULT_X4B: keep = 1'b1;
            default:  keep = 1'b1;
        endcase
        step_up = is_fwd & keep & ~gate;
        step_dn = is_rev & keep & ~gate;
    end

    // R5: gate blocks every step
    p_gate_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> !(step_up || step_dn));

    // R5: simultaneous change of both channels never counts
    p_double_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ab_in ^ prev_q) == 2'b11) |-> !(step_up || step_dn));

endmodule

// File: rtl/qc_capture.sv
module qc_capture
    import qc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sig,
    output logic take,
    output logic valid
);
    cap_state_t state_q;
    cap_state_t state_d;
    logic       sig_q;
    logic       rise;

    assign rise = sig & ~sig_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_OFF:   if (enable) state_d = CAP_ARMED;
            CAP_ARMED: begin
                if (!enable)   state_d = CAP_OFF;
                else if (rise) state_d = CAP_HELD;
            end
            CAP_HELD:  if (!enable) state_d = CAP_OFF;
            default:   state_d = CAP_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_OFF;
            sig_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sig_q   <= sig;
        end
    end

    // Outputs
    always_comb begin
        take  = (state_q == CAP_ARMED) && enable && rise;
        valid = (state_q == CAP_HELD);
    end

    // R9 / R10: a capture leaves the valid flag set
    p_take_sets_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> valid);

    // R9 / R10: once valid, further edges capture nothing while enabled
    p_first_edge_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && enable) |=> (valid && !take));

endmodule

// File: rtl/qc_counter.sv
module qc_counter
    import qc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             preset_req,
    input  logic [CNT_W-1:0] preset_val,
    output logic [CNT_W-1:0] count,
    output logic             overflow,
    output logic             underflow,
    output logic             preset_ack
);
    localparam longint unsigned FULL_SPAN = (longint'(1) << CNT_W) - 1;
    localparam logic [CNT_W-1:0] LOW_MARK  = CNT_W'(FULL_SPAN / 3);
    localparam logic [CNT_W-1:0] HIGH_MARK = CNT_W'(2 * (FULL_SPAN / 3));
    localparam logic [CNT_W-1:0] TOP_VAL   = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    wrap_state_t      wrap_q, wrap_d;
    logic             pre_q;
    logic             ack_q, ack_d;
    logic             load;

    assign load = preset_req & ~pre_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_d = wrap_q;
        if (load) begin
            cnt_d = preset_val;
        end else if (step_up) begin
            cnt_d = cnt_q + 1'b1;
            unique case (wrap_q)
                WRAP_CLEAR,
                WRAP_UNDER: if (cnt_q == TOP_VAL)  wrap_d = WRAP_OVER;
                WRAP_OVER:  if (cnt_q == LOW_MARK) wrap_d = WRAP_CLEAR;
                default:    wrap_d = WRAP_CLEAR;
            endcase
        end else if (step_dn) begin
            cnt_d = cnt_q - 1'b1;
            unique case (wrap_q)
                WRAP_CLEAR,
                WRAP_OVER:  if (cnt_q == '0)        wrap_d = WRAP_UNDER;
                WRAP_UNDER: if (cnt_q == HIGH_MARK) wrap_d = WRAP_CLEAR;
                default:    wrap_d = WRAP_CLEAR;
            endcase
        end
        ack_d = preset_req & (ack_q | load);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= WRAP_CLEAR;
            pre_q  <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wrap_q <= wrap_d;
            pre_q  <= preset_req;
            ack_q  <= ack_d;
        end
    end

    // Outputs
    always_comb begin
        count      = cnt_q;
        overflow   = (wrap_q == WRAP_OVER);
        underflow  = (wrap_q == WRAP_UNDER);
        preset_ack = ack_q;
    end

    // R5: without a step or a load the count holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_up && !step_dn && !load) |=> $stable(cnt_q));

    // R6: a load takes the preset value and raises the acknowledge
    p_preset_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(preset_val)) && ack_q);

    // R7: up step from the top wraps to zero with the overflow flag
    p_wrap_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !load && cnt_q == TOP_VAL) |=> (cnt_q == '0) && overflow && !underflow);

    // R8: down step from zero wraps to the top with the underflow flag
    p_wrap_under_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !load && cnt_q == '0) |=> (cnt_q == TOP_VAL) && underflow && !overflow);

endmodule

// File: rtl/quad_counter.sv
module quad_counter
    import qc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_index,
    input  logic             latch_in,
    input  logic             gate_in,
    input  logic [1:0]       mult_sel,
    input  logic [7:0]       ctrl_byte,
    input  logic [CNT_W-1:0] preset_value,
    output logic [7:0]       status_byte,
    output logic [CNT_W-1:0] count_value,
    output logic [CNT_W-1:0] latch_value
);
    localparam int N_SYNC = 5;

    logic [N_SYNC-1:0] raw_in, synced;
    logic s_a, s_b, s_idx, s_ext, s_gate;
    logic fast;
    logic idx_en, ext_en, preset_req;
    logic step_up, step_dn;
    logic take_idx, take_ext, valid_idx, valid_ext;
    logic ovf, unf, ack;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] latch_q;

    assign raw_in = {gate_in, latch_in, enc_index, enc_a, enc_b};

    qc_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    assign {s_gate, s_ext, s_idx, s_a, s_b} = synced;

    // Fast mode masks every control bit other than itself
    assign fast       = ctrl_byte[CB_FAST];
    assign idx_en     = ctrl_byte[CB_IDX_EN] & ~fast;
    assign ext_en     = ctrl_byte[CB_EXT_EN] & ~fast;
    assign preset_req = ctrl_byte[CB_PRESET] & ~fast;

    qc_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .ab_in   ({s_a, s_b}),
        .gate    (s_gate),
        .mult    (mult_sel),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    qc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .preset_req (preset_req),
        .preset_val (preset_value),
        .count      (cnt),
        .overflow   (ovf),
        .underflow  (unf),
        .preset_ack (ack)
    );

    qc_capture u_cap_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (idx_en),
        .sig    (s_idx),
        .take   (take_idx),
        .valid  (valid_idx)
    );

    qc_capture u_cap_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ext_en),
        .sig    (s_ext),
        .take   (take_ext),
        .valid  (valid_ext)
    );

    // Shared capture register: both sources take the same live count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    latch_q <= '0;
        else if (take_idx || take_ext) latch_q <= cnt;
    end

    assign count_value = cnt;
    assign latch_value = latch_q;
    assign status_byte = {3'b000, ovf, unf, ack, valid_ext, valid_idx};

    // R9: capture register only moves on a capture event
    p_latch_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_idx || take_ext) |=> $stable(latch_q));

    // R11: fast mode blocks both capture sources
    p_fast_no_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fast |-> !(take_idx || take_ext));

    // R11: spare control bits are held at zero by the host
    p_spare_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctrl_byte & CB_SPARE_MASK) == 0);

endmodule

// File: tb/tb_quad_counter.sv
module tb_quad_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_index = 1'b0;
    logic        latch_in = 1'b0, gate_in = 1'b0;
    logic [1:0]  mult_sel = 2'd0;
    logic [7:0]  ctrl_byte = 8'h00;
    logic [15:0] preset_value = 16'h0000;
    logic [7:0]  status_byte;
    logic [15:0] count_value, latch_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_counter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_a        (enc_a),
        .enc_b        (enc_b),
        .enc_index    (enc_index),
        .latch_in     (latch_in),
        .gate_in      (gate_in),
        .mult_sel     (mult_sel),
        .ctrl_byte    (ctrl_byte),
        .preset_value (preset_value),
        .status_byte  (status_byte),
        .count_value  (count_value),
        .latch_value  (latch_value)
    );

    // Vector: {a, b, mult[1:0], gate, expected count[15:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 2'd0, 1'b0, 16'd1},  // R2 forward
        {1'b1, 1'b1, 2'd0, 1'b0, 16'd2},  // R2
        {1'b0, 1'b1, 2'd0, 1'b0, 16'd3},  // R2
        {1'b0, 1'b0, 2'd0, 1'b0, 16'd4},  // R2
        {1'b0, 1'b1, 2'd0, 1'b0, 16'd3},  // R2 reverse
        {1'b0, 1'b0, 2'd0, 1'b0, 16'd4},  // R2
        {1'b1, 1'b0, 2'd1, 1'b0, 16'd5},  // R3 A rises
        {1'b1, 1'b1, 2'd1, 1'b0, 16'd5},  // R3 B alone
        {1'b0, 1'b1, 2'd1, 1'b0, 16'd6},  // R3 A falls
        {1'b0, 1'b0, 2'd1, 1'b0, 16'd6},  // R3 B alone
        {1'b1, 1'b0, 2'd2, 1'b0, 16'd7},  // R4 00->10
        {1'b1, 1'b1, 2'd2, 1'b0, 16'd7},  // R4
        {1'b0, 1'b1, 2'd2, 1'b0, 16'd7},  // R4
        {1'b0, 1'b0, 2'd2, 1'b0, 16'd7},  // R4
        {1'b0, 1'b1, 2'd2, 1'b0, 16'd7},  // R4 reverse
        {1'b1, 1'b1, 2'd2, 1'b0, 16'd7},  // R4
        {1'b1, 1'b0, 2'd2, 1'b0, 16'd7},  // R4
        {1'b0, 1'b0, 2'd2, 1'b0, 16'd6},  // R4 10->00
        {1'b1, 1'b0, 2'd0, 1'b1, 16'd6},  // R5 gated
        {1'b0, 1'b0, 2'd0, 1'b1, 16'd6},  // R5 gated
        {1'b1, 1'b1, 2'd0, 1'b0, 16'd6},  // R5 double jump
        {1'b0, 1'b0, 2'd0, 1'b0, 16'd6},  // R5 double jump
        {1'b1, 1'b0, 2'd0, 1'b0, 16'd7}   // R2 after ungating
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic fwd();
        unique case ({enc_a, enc_b})
            2'b00: {enc_a, enc_b} = 2'b10;
            2'b10: {enc_a, enc_b} = 2'b11;
            2'b11: {enc_a, enc_b} = 2'b01;
            default: {enc_a, enc_b} = 2'b00;
        endcase
        settle();
    endtask

    task automatic rev();
        unique case ({enc_a, enc_b})
            2'b00: {enc_a, enc_b} = 2'b01;
            2'b01: {enc_a, enc_b} = 2'b11;
            2'b11: {enc_a, enc_b} = 2'b10;
            default: {enc_a, enc_b} = 2'b00;
        endcase
        settle();
    endtask

    task automatic do_preset(input logic [15:0] v);
        preset_value = v;
        ctrl_byte = 8'h04;
        settle();
        ctrl_byte = 8'h00;
        settle();
    endtask

    task automatic pulse_ext();
        latch_in = 1'b1; settle();
        latch_in = 1'b0; settle();
    endtask

    task automatic pulse_idx();
        enc_index = 1'b1; settle();
        enc_index = 1'b0; settle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", 32'(count_value), 0);
        chk("R1 latch", 32'(latch_value), 0);
        chk("R1 status", 32'(status_byte), 0);

        for (int i = 0; i < NVEC; i++) begin
            {enc_a, enc_b, mult_sel, gate_in} = VEC[i][20:16];
            settle();
            chk($sformatf("R2-R5 vector %0d count", i), 32'(count_value), 32'(VEC[i][15:0]));
        end
        mult_sel = 2'd0;

        // R6 preset and acknowledge
        preset_value = 16'hFFFF;
        ctrl_byte = 8'h04;
        settle();
        chk("R6 preset count", 32'(count_value), 65535);
        chk("R6 ack set", 32'(status_byte), 32'h04);
        ctrl_byte = 8'h00;
        settle();
        chk("R6 ack clear", 32'(status_byte), 0);

        // R7 overflow set, survives preset, clears at the one-third crossing
        fwd();
        chk("R7 wrap count", 32'(count_value), 0);
        chk("R7 overflow set", 32'(status_byte), 32'h10);
        do_preset(16'd21845);
        chk("R7 overflow after preset", 32'(status_byte), 32'h10);
        fwd();
        chk("R7 crossing count", 32'(count_value), 21846);
        chk("R7 overflow cleared", 32'(status_byte), 0);

        // R8 underflow set, clears at the two-thirds crossing
        do_preset(16'd0);
        rev();
        chk("R8 wrap count", 32'(count_value), 65535);
        chk("R8 underflow set", 32'(status_byte), 32'h08);
        do_preset(16'd43690);
        rev();
        chk("R8 crossing count", 32'(count_value), 43689);
        chk("R8 underflow cleared", 32'(status_byte), 0);

        // R8 / R7 each flag clears the other
        do_preset(16'hFFFF);
        fwd();
        chk("R7 overflow again", 32'(status_byte), 32'h10);
        rev();
        chk("R8 underflow clears overflow", 32'(status_byte), 32'h08);
        fwd();
        chk("R7 overflow clears underflow", 32'(status_byte), 32'h10);
        do_preset(16'd21845);
        fwd();
        chk("R7 flags clean", 32'(status_byte), 0);

        // R9 external capture
        ctrl_byte = 8'h02;
        settle();
        pulse_ext();
        chk("R9 first capture", 32'(latch_value), 21846);
        chk("R9 valid set", 32'(status_byte), 32'h02);
        fwd();
        pulse_ext();
        chk("R9 second edge ignored", 32'(latch_value), 21846);
        chk("R9 valid held", 32'(status_byte), 32'h02);
        ctrl_byte = 8'h00;
        settle();
        chk("R9 valid cleared", 32'(status_byte), 0);
        chk("R9 value kept", 32'(latch_value), 21846);
        ctrl_byte = 8'h02;
        settle();
        pulse_ext();
        chk("R9 re-armed capture", 32'(latch_value), 21847);
        ctrl_byte = 8'h00;
        settle();
        fwd();
        pulse_ext();
        chk("R9 disabled edge ignored", 32'(latch_value), 21847);
        chk("R9 disabled status", 32'(status_byte), 0);

        // R10 index capture
        ctrl_byte = 8'h01;
        settle();
        pulse_idx();
        chk("R10 first capture", 32'(latch_value), 21848);
        chk("R10 valid set", 32'(status_byte), 32'h01);
        fwd();
        pulse_idx();
        chk("R10 second edge ignored", 32'(latch_value), 21848);
        ctrl_byte = 8'h00;
        settle();
        chk("R10 valid cleared", 32'(status_byte), 0);

        // R11 fast mode
        preset_value = 16'd1234;
        ctrl_byte = 8'h27;
        settle();
        chk("R11 no preset", 32'(count_value), 21849);
        chk("R11 status clear", 32'(status_byte), 0);
        pulse_ext();
        pulse_idx();
        chk("R11 no capture", 32'(latch_value), 21848);
        fwd();
        chk("R11 counting works", 32'(count_value), 21850);
        ctrl_byte = 8'h00;
        settle();
        chk("R11 exit keeps count", 32'(count_value), 21850);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule